// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block turns a single-cycle watchdog expiry trigger into a timed reset pulse on an output pin. The pulse length is counted in ticks of a 1 MHz enable strobe. A register holds three settings: the duration, the pin polarity and the pin drive style. The duration field stores the wanted tick count minus one, so a field value of zero gives a one-tick pulse.

The polarity and drive-style flags are protected against accidental writes. They change only when one of four key values is written into the register's top byte. Any other top-byte value leaves them as they were, while the duration field always takes the written value. The block gives out a pin level and an output-enable. In open-drain mode the output-enable is raised only while the pin is being pulled to its active level. In push-pull mode the output-enable stays high all the time.

The sequencer has two states. In `ST_IDLE` no pulse is produced, and in `ST_ASSERT` the pulse is driven. It has three transitions:
- FIRE: `ST_IDLE` to `ST_ASSERT` when the trigger is seen. The count is loaded from the duration field.
- RELOAD: `ST_ASSERT` to `ST_ASSERT` when the trigger is seen again. The count is loaded again.
- EXPIRE: `ST_ASSERT` to `ST_IDLE` on a tick when the count is already zero.

Top module: `wdt_rst_pulse`

## Requirements
- R1: After reset the register reads 0x000000FF. This means duration field 255, active-low polarity and open-drain drive. The sequencer is idle, the pin sits at its inactive level (high) and the output-enable is low.
- R2: Every write loads bits 19:0 into the duration field. Bits 29:20 always read as zero.
- R3: Top byte 0xA5 selects active-high polarity, and top byte 0x5A selects active-low polarity.
- R4: Top byte 0xA8 selects push-pull drive, and top byte 0x8A selects open-drain drive.
- R5: Any other top-byte value leaves both polarity and drive unchanged.
- R6: On read, bit 31 is 1 for active-high polarity and bit 30 is 1 for push-pull drive.
- R7: A trigger sampled at a clock edge puts the pulse on the pin from that edge onward. With a tick on every cycle, the pulse lasts exactly (field + 1) cycles.
- R8: The count advances only on cycles where the tick strobe is high. With no ticks the pulse holds.
- R9: A trigger during an active pulse reloads the count, so the pulse ends (field + 1) ticks after the last trigger.
- R10: In open-drain mode the output-enable is high only while the pulse is active. In push-pull mode it is always high.
- R11: During the pulse the pin equals the polarity bit (1 for active-high). Outside the pulse the pin equals the inverse of the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | 1 MHz count enable, one cycle wide |
| trigger | input | 1 | Watchdog expiry, starts or restarts the pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| pin_level | output | 1 | Level presented to the reset pad |
| pin_oe | output | 1 | Pad output-enable |

## Verification
Two of the block's functions can fall in the same cycle. A trigger can arrive while the pulse is being counted down, and a key write can change polarity or drive mode while the pulse is on the pin. The bench provokes the first case by re-firing the trigger partway through a pulse. It judges the result by the total number of active cycles, which must equal the elapsed cycles plus field + 1. It provokes the second case by sweeping all four polarity and drive combinations around pulses of several lengths. In each combination it checks the pin level and output-enable against the polarity and drive flags, both inside and outside the pulse.

// File: rtl/wdt_rst_pulse_pkg.sv
package wdt_rst_pulse_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ASSERT = 1'b1
    } pulse_state_t;

    typedef struct packed {
        logic act_high;
        logic push_pull;
    } pad_cfg_t;

    localparam logic [7:0] KEY_ACT_HIGH  = 8'hA5;
    localparam logic [7:0] KEY_ACT_LOW   = 8'h5A;
    localparam logic [7:0] KEY_PUSH_PULL = 8'hA8;
    localparam logic [7:0] KEY_OPEN_DRN  = 8'h8A;

    localparam int POL_BIT = 31;
    localparam int DRV_BIT = 30;

endpackage

// File: rtl/wdt_pulse_cfg.sv
module wdt_pulse_cfg
    import wdt_rst_pulse_pkg::*;
#(
    parameter int          CNT_W     = 20,
    parameter logic [CNT_W-1:0] DUR_RESET = 'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [CNT_W-1:0] dur_o,
    output pad_cfg_t         cfg_o,
    output logic [31:0]      rd_data_o
);

    localparam int TOP_LSB = 24;

    logic [7:0]       key_byte;
    pad_cfg_t         cfg_q, cfg_d;
    logic [CNT_W-1:0] dur_q;
    logic             unused_mid;

    assign key_byte   = wr_data[31:TOP_LSB];
    assign unused_mid = ^wr_data[TOP_LSB-1:CNT_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (key_byte)
                KEY_ACT_HIGH:  cfg_d.act_high  = 1'b1;
                KEY_ACT_LOW:   cfg_d.act_high  = 1'b0;
                KEY_PUSH_PULL: cfg_d.push_pull = 1'b1;
                KEY_OPEN_DRN:  cfg_d.push_pull = 1'b0;
                default:       cfg_d           = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dur_q <= DUR_RESET;
        end else begin
            cfg_q <= cfg_d;
            if (wr_en) begin
                dur_q <= wr_data[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data_o              = '0;
        rd_data_o[CNT_W-1:0]   = dur_q;
        rd_data_o[POL_BIT]     = cfg_q.act_high;
        rd_data_o[DRV_BIT]     = cfg_q.push_pull;
    end

    assign dur_o = dur_q;
    assign cfg_o = cfg_q;

    // R5
    key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_byte != KEY_ACT_HIGH && key_byte != KEY_ACT_LOW &&
         key_byte != KEY_PUSH_PULL && key_byte != KEY_OPEN_DRN)
        |=> $stable(rd_data_o[31:30]));

    // R2
    dur_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data_o[CNT_W-1:0] == $past(wr_data[CNT_W-1:0]));

endmodule

// File: rtl/wdt_pulse_fsm.sv
module wdt_pulse_fsm
    import wdt_rst_pulse_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trigger,
    input  logic [CNT_W-1:0] dur,
    output logic             active_o
);

    pulse_state_t     st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (trigger) begin
                    st_d  = ST_ASSERT;
                    cnt_d = dur;
                end
            end
            ST_ASSERT: begin
                if (trigger) begin
                    cnt_d = dur;
                end else if (tick) begin
                    if (cnt_q == '0) begin
                        st_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_ASSERT: active_o = 1'b1;
            default:   active_o = 1'b0;
        endcase
    end

    // R7
    fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> active_o);

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> cnt_q == $past(dur));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !tick && !trigger) |=> (active_o && $stable(cnt_q)));

    // R7
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !trigger) |=> !active_o);

endmodule

// File: rtl/wdt_pad_drive.sv
module wdt_pad_drive
    import wdt_rst_pulse_pkg::*;
(
    input  logic     active,
    input  pad_cfg_t cfg,
    output logic     pin_o,
    output logic     oe_o
);

    always_comb begin
        pin_o = active ? cfg.act_high : ~cfg.act_high;
        oe_o  = cfg.push_pull | active;
    end

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse
    import wdt_rst_pulse_pkg::*;
#(
    parameter int               CNT_W     = 20,
    parameter logic [CNT_W-1:0] DUR_RESET = 'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_us,
    input  logic        trigger,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pin_level,
    output logic        pin_oe
);

    logic [CNT_W-1:0] dur;
    pad_cfg_t         cfg;
    logic             active;

    wdt_pulse_cfg #(.CNT_W(CNT_W), .DUR_RESET(DUR_RESET)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .dur_o     (dur),
        .cfg_o     (cfg),
        .rd_data_o (rd_data)
    );

    wdt_pulse_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_us),
        .trigger  (trigger),
        .dur      (dur),
        .active_o (active)
    );

    wdt_pad_drive u_pad (
        .active (active),
        .cfg    (cfg),
        .pin_o  (pin_level),
        .oe_o   (pin_oe)
    );

    // R10
    od_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[DRV_BIT] && !active) |-> !pin_oe);

    // R10
    pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DRV_BIT] |-> pin_oe);

    // R11
    pol_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pin_level == rd_data[POL_BIT]));

endmodule

// File: tb/wdt_rst_pulse_tb.sv
module wdt_rst_pulse_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b1;
    logic        trigger = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pin_level, pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic        m_pol = 1'b0;
    logic        m_pp  = 1'b0;
    logic [19:0] m_dur = 20'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_rst_pulse u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .trigger(trigger),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pin_level(pin_level), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd();
        return {m_pol, m_pp, 10'b0, m_dur};
    endfunction

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        case (v[31:24])
            8'hA5: m_pol = 1'b1;
            8'h5A: m_pol = 1'b0;
            8'hA8: m_pp  = 1'b1;
            8'h8A: m_pp  = 1'b0;
            default: ;
        endcase
        m_dur = v[19:0];
    endtask

    task automatic fire();
        @(negedge clk);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    // counts active samples at successive negedges, starting at the current one
    task automatic count_active(input string req, output int n);
        n = 0;
        for (int k = 0; k < 5000; k++) begin
            if (pin_level !== m_pol) break;
            chk(req, {31'b0, pin_oe}, 32'd1);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd", rd_data, 32'h0000_00FF);
        chk("R1 pin", {31'b0, pin_level}, 32'd1);
        chk("R1 oe", {31'b0, pin_oe}, 32'd0);

        // R2 R3 R4 R5 R6: sweep every top-byte value
        for (int kb = 0; kb < 256; kb++) begin
            reg_write({kb[7:0], 4'hF, 20'(kb * 4099 + 7)});
            chk("R2/R3/R4/R5/R6 rd", rd_data, model_rd());
        end
        // R3 R4 explicit key pairs
        reg_write(32'hA500_0001); chk("R3 act-high", rd_data, 32'h8000_0001 | {1'b0, m_pp, 30'b0});
        reg_write(32'h5A00_0001); chk("R3 act-low", {31'b0, rd_data[31]}, 32'd0);
        reg_write(32'hA800_0002); chk("R4 push-pull", {31'b0, rd_data[30]}, 32'd1);
        reg_write(32'h8A00_0002); chk("R4 open-drain", {31'b0, rd_data[30]}, 32'd0);
        reg_write(32'h3FF0_0004); chk("R5 other key", rd_data, 32'h0000_0004);

        // R7 R10 R11: durations x all four pin configurations
        for (int cfgi = 0; cfgi < 4; cfgi++) begin
            reg_write(cfgi[0] ? 32'hA500_0000 : 32'h5A00_0000);
            reg_write(cfgi[1] ? 32'hA800_0000 : 32'h8A00_0000);
            for (int d = 0; d < 7; d++) begin
                reg_write({8'h00, 4'h0, 20'(d)});
                chk("R11 idle pin", {31'b0, pin_level}, {31'b0, ~m_pol});
                chk("R10 idle oe", {31'b0, pin_oe}, {31'b0, m_pp});
                fire();
                count_active("R10 active oe", n);
                chk("R7 duration", n, d + 1);
                chk("R11 after pin", {31'b0, pin_level}, {31'b0, ~m_pol});
                chk("R10 after oe", {31'b0, pin_oe}, {31'b0, m_pp});
            end
        end

        // R9 retrigger mid-pulse
        reg_write(32'h0000_0003);
        fire();
        @(negedge clk);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        count_active("R9 oe", n);
        chk("R9 retrigger length", n + 2, 32'd6);

        // R8 count holds without ticks
        reg_write(32'h0000_0002);
        tick_us = 1'b0;
        fire();
        repeat (20) @(negedge clk);
        chk("R8 hold pin", {31'b0, pin_level}, {31'b0, m_pol});
        tick_us = 1'b1;
        count_active("R8 oe", n);
        chk("R8 resume length", n, 32'd3);
        // R8 ticks every other cycle: 3 ticks need 6 cycles
        fire();
        n = 0;
        for (int k = 0; k < 40; k++) begin
            tick_us = k[0];
            if (pin_level !== m_pol) break;
            n++;
            @(negedge clk);
        end
        tick_us = 1'b1;
        chk("R8 half-rate length", n, 32'd6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule